// File: doc/BRIEF.md
# Variable-Length Command Record Parser

This block walks a run of packed, variable-length command records held in wide memory words and produces one decoded write command per record. A write command is made of a channel number, a timestamp, a register address and a data value of 1 to `DATA_MAX` bytes. Each record opens with a byte that gives its own total length. Records follow one another with no padding, so a record may begin in one memory word and end in a later one.

Software places a byte address on `base_i` and pulses `start_i`. The block then raises `enable_o` and reads whole words through a request/response stream with valid/ready handshakes, one word in flight at a time. It takes bytes from each word starting at the lowest lane, rebuilds each record and hands the finished command to a valid/ready output port. A zero length byte ends the run. A length byte that cannot describe a legal record also ends the run. When the run ends, `enable_o` drops by itself, and software polls it to learn that the run has finished. A later run may start from a different base address.

The block consumes one record byte per cycle. While the output holds a command that has not been accepted, parsing of the next record carries on; it waits only at the final byte of that record.

Top module: `rec_stream_parser`

## Requirements
- R1: A record is a length byte L (total record bytes, L included), then channel (3 bytes), timestamp (8 bytes), register address (2 bytes), then L-14 data bytes. Every field is least significant byte first, so data byte 0 appears on `cmd_data_o[7:0]`.
- R2: `cmd_dlen_o` equals L-14 and lies in 1..DATA_MAX. All bits of `cmd_data_o` above bit 8*`cmd_dlen_o`-1 are zero.
- R3: A length byte of 0 ends the run and produces no command.
- R4: A length byte in 1..14, or above 14+DATA_MAX, is treated as a terminator. It produces no command, and nothing after it in memory produces one.
- R5: Word requests go to `base_i`, `base_i`+WORD_BYTES, `base_i`+2*WORD_BYTES, and so on in order. Bytes are taken from lane 0 (bits 7:0) upward, and records that cross a word boundary are rebuilt intact.
- R6: At most one word request is in flight at a time. No request is made while `enable_o` is low. A new word is requested only after the last lane of the current word has been consumed. A run therefore fetches exactly floor(terminator offset / WORD_BYTES)+1 words.
- R7: `start_i` while `enable_o` is low sets `enable_o` in the next cycle and latches `base_i`. `start_i` while `enable_o` is high is ignored and leaves the address sequence unchanged.
- R8: `enable_o` clears by itself once the terminator has been taken. This happens only after every command of the run has been accepted at the output. `cmd_valid_o` is never high while `enable_o` is low.
- R9: While `cmd_ready_i` is low, `cmd_valid_o` stays high and the command payload stays stable. No record is lost during such a stall.
- R10: Commands leave in the order their records sit in memory. Back-to-back runs from different base addresses each produce exactly their own records, with none lost or repeated.
- R11: `req_valid_o` and `req_addr_o` hold steady until `req_ready_i` accepts the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Pulse that starts a run while idle |
| base_i | input | ADDR_W | Byte address of the first word of the run |
| enable_o | output | 1 | High while a run is in progress; clears by itself |
| req_valid_o | output | 1 | Word request valid |
| req_ready_i | input | 1 | Word request accepted |
| req_addr_o | output | ADDR_W | Byte address of the requested word |
| rsp_valid_i | input | 1 | Word response valid |
| rsp_ready_o | output | 1 | Parser is waiting for a word |
| rsp_data_i | input | 8*WORD_BYTES | Word contents, byte lane 0 in bits 7:0 |
| cmd_valid_o | output | 1 | Decoded command valid |
| cmd_ready_i | input | 1 | Command accepted downstream |
| cmd_chan_o | output | 24 | Channel number |
| cmd_stamp_o | output | 64 | Timestamp |
| cmd_rega_o | output | 16 | Register address |
| cmd_data_o | output | 8*DATA_MAX | Data value, zero-extended |
| cmd_dlen_o | output | $clog2(DATA_MAX+1) | Number of data bytes |

## Verification
The clash that matters is the final byte of one record arriving in the same cycle that the downstream side accepts the command already held at the output. When that happens, the new command has to load into the slot just as the old one leaves, with neither dropped nor emitted twice. The bench provokes this by running the output ready from a random draw at several densities, from nearly always ready down to mostly stalled, while short records arrive only 15 cycles apart. It judges the outcome by matching each accepted command, in order, against the records it wrote into memory, and by checking that a held command does not change until it is accepted.

// File: rtl/rec_stream_pkg.sv
package rec_stream_pkg;
  localparam int CHAN_BYTES  = 3;
  localparam int STAMP_BYTES = 8;
  localparam int REGA_BYTES  = 2;
  // length byte plus fixed fields
  localparam int HDR_BYTES   = 1 + CHAN_BYTES + STAMP_BYTES + REGA_BYTES;
  localparam int FIELD_BYTES = HDR_BYTES - 1;
  localparam int CHAN_W      = 8 * CHAN_BYTES;
  localparam int STAMP_W     = 8 * STAMP_BYTES;
  localparam int REGA_W      = 8 * REGA_BYTES;
  localparam int POS_W       = 8;

  // little-endian field bytes: channel occupies the low end
  typedef struct packed {
    logic [REGA_W-1:0]  rega;
    logic [STAMP_W-1:0] stamp;
    logic [CHAN_W-1:0]  chan;
  } fields_t;

  typedef enum logic [1:0] {
    FS_IDLE,
    FS_REQ,
    FS_WAIT,
    FS_HAVE
  } fetch_st_e;
endpackage

// File: rtl/rsp_word_fetch.sv
module rsp_word_fetch
  import rec_stream_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 64
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [ADDR_W-1:0]       base_i,
  input  logic                    run_i,
  input  logic                    stop_i,
  output logic                    req_valid_o,
  input  logic                    req_ready_i,
  output logic [ADDR_W-1:0]       req_addr_o,
  input  logic                    rsp_valid_i,
  output logic                    rsp_ready_o,
  input  logic [8*WORD_BYTES-1:0] rsp_data_i,
  output logic                    byte_valid_o,
  output logic [7:0]              byte_o,
  input  logic                    byte_take_i
);
  localparam int WORD_W = 8 * WORD_BYTES;
  localparam int LANE_W = $clog2(WORD_BYTES);

  fetch_st_e         st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] word_q;
  logic [LANE_W-1:0] lane_q;
  logic              last_lane;

  assign last_lane = (lane_q == LANE_W'(WORD_BYTES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= FS_IDLE;
      addr_q <= '0;
      word_q <= '0;
      lane_q <= '0;
    end else begin
      if (start_i) addr_q <= base_i;
      case (st_q)
        FS_IDLE: if (run_i) st_q <= FS_REQ;
        FS_REQ: begin
          if (req_ready_i) begin
            st_q   <= FS_WAIT;
            addr_q <= addr_q + ADDR_W'(WORD_BYTES);
          end
        end
        FS_WAIT: begin
          if (rsp_valid_i) begin
            st_q   <= FS_HAVE;
            word_q <= rsp_data_i;
            lane_q <= '0;
          end
        end
        FS_HAVE: begin
          if (stop_i) begin
            st_q <= FS_IDLE;
          end else if (byte_take_i) begin
            lane_q <= lane_q + LANE_W'(1);
            // word drained: go straight to the next request
            if (last_lane) st_q <= FS_REQ;
          end
        end
        default: st_q <= FS_IDLE;
      endcase
    end
  end

  assign req_valid_o  = (st_q == FS_REQ);
  assign req_addr_o   = addr_q;
  assign rsp_ready_o  = (st_q == FS_WAIT);
  assign byte_valid_o = (st_q == FS_HAVE);
  assign byte_o       = word_q[8*lane_q +: 8];
endmodule

// File: rtl/rsp_rec_asm.sv
module rsp_rec_asm
  import rec_stream_pkg::*;
#(
  parameter int DATA_MAX = 64
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          byte_valid_i,
  input  logic [7:0]                    byte_i,
  output logic                          byte_take_o,
  input  logic                          slot_free_i,
  input  logic                          slot_empty_i,
  output logic                          rec_done_o,
  output logic                          term_o,
  output fields_t                       fields_o,
  output logic [8*DATA_MAX-1:0]         data_o,
  output logic [$clog2(DATA_MAX+1)-1:0] dlen_o
);
  localparam int DATA_W  = 8 * DATA_MAX;
  localparam int DLEN_W  = $clog2(DATA_MAX + 1);
  localparam int MAX_LEN = HDR_BYTES + DATA_MAX;
  localparam int HDR_W   = 8 * FIELD_BYTES;

  logic [POS_W-1:0]  pos_q;
  logic [7:0]        len_q;
  logic [HDR_W-1:0]  hdr_q, hdr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              at_len, len_ok, last;
  logic              take, term, done;

  assign at_len = (pos_q == '0);
  assign len_ok = (byte_i >= 8'(HDR_BYTES + 1)) && (byte_i <= 8'(MAX_LEN));
  assign last   = !at_len && (pos_q == (len_q - 8'd1));

  always_comb begin
    take = 1'b0;
    term = 1'b0;
    done = 1'b0;
    if (byte_valid_i) begin
      if (at_len) begin
        if (len_ok) begin
          take = 1'b1;
        end else if (slot_empty_i) begin
          // end of run waits until the last command has left
          take = 1'b1;
          term = 1'b1;
        end
      end else if (!last || slot_free_i) begin
        take = 1'b1;
        done = last;
      end
    end
  end

  always_comb begin
    hdr_d  = hdr_q;
    data_d = data_q;
    if (take && !at_len) begin
      for (int k = 0; k < FIELD_BYTES; k++) begin
        if (pos_q == POS_W'(k + 1)) hdr_d[8*k +: 8] = byte_i;
      end
      for (int k = 0; k < DATA_MAX; k++) begin
        if (pos_q == POS_W'(HDR_BYTES + k)) data_d[8*k +: 8] = byte_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      len_q  <= '0;
      hdr_q  <= '0;
      data_q <= '0;
    end else if (take) begin
      if (at_len) begin
        if (!term) begin
          len_q  <= byte_i;
          pos_q  <= POS_W'(1);
          hdr_q  <= '0;
          data_q <= '0;
        end
      end else begin
        hdr_q  <= hdr_d;
        data_q <= data_d;
        pos_q  <= last ? '0 : pos_q + POS_W'(1);
      end
    end
  end

  assign byte_take_o = take;
  assign term_o      = term;
  assign rec_done_o  = done;
  assign fields_o    = fields_t'(hdr_d);
  assign data_o      = data_d;
  assign dlen_o      = DLEN_W'(len_q - 8'(HDR_BYTES));
endmodule

// File: rtl/rsp_cmd_slot.sv
module rsp_cmd_slot
  import rec_stream_pkg::*;
#(
  parameter int DATA_MAX = 64
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          load_i,
  input  fields_t                       fields_i,
  input  logic [8*DATA_MAX-1:0]         data_i,
  input  logic [$clog2(DATA_MAX+1)-1:0] dlen_i,
  output logic                          slot_free_o,
  output logic                          slot_empty_o,
  output logic                          valid_o,
  input  logic                          ready_i,
  output fields_t                       fields_o,
  output logic [8*DATA_MAX-1:0]         data_o,
  output logic [$clog2(DATA_MAX+1)-1:0] dlen_o
);
  logic valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      fields_o <= '0;
      data_o   <= '0;
      dlen_o   <= '0;
    end else if (load_i) begin
      valid_q  <= 1'b1;
      fields_o <= fields_i;
      data_o   <= data_i;
      dlen_o   <= dlen_i;
    end else if (ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o      = valid_q;
  assign slot_free_o  = !valid_q || ready_i;
  assign slot_empty_o = !valid_q;
endmodule

// File: rtl/rec_stream_parser.sv
module rec_stream_parser
  import rec_stream_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 64,
  parameter int DATA_MAX   = 64
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic [ADDR_W-1:0]             base_i,
  output logic                          enable_o,
  output logic                          req_valid_o,
  input  logic                          req_ready_i,
  output logic [ADDR_W-1:0]             req_addr_o,
  input  logic                          rsp_valid_i,
  output logic                          rsp_ready_o,
  input  logic [8*WORD_BYTES-1:0]       rsp_data_i,
  output logic                          cmd_valid_o,
  input  logic                          cmd_ready_i,
  output logic [CHAN_W-1:0]             cmd_chan_o,
  output logic [STAMP_W-1:0]            cmd_stamp_o,
  output logic [REGA_W-1:0]             cmd_rega_o,
  output logic [8*DATA_MAX-1:0]         cmd_data_o,
  output logic [$clog2(DATA_MAX+1)-1:0] cmd_dlen_o
);
  localparam int DATA_W = 8 * DATA_MAX;
  localparam int DLEN_W = $clog2(DATA_MAX + 1);

  if (WORD_BYTES < 2 || (WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_word
    $error("WORD_BYTES must be a power of two of at least 2");
  end
  if (DATA_MAX < 1 || HDR_BYTES + DATA_MAX > 255) begin : g_bad_data
    $error("DATA_MAX must keep a record length within one byte");
  end

  logic              enable_q, start_go;
  logic              byte_valid, byte_take;
  logic [7:0]        byte_val;
  logic              slot_free, slot_empty;
  logic              rec_done, term;
  fields_t           asm_fields, out_fields;
  logic [DATA_W-1:0] asm_data;
  logic [DLEN_W-1:0] asm_dlen;

  assign start_go = start_i && !enable_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       enable_q <= 1'b0;
    else if (term)     enable_q <= 1'b0;
    else if (start_go) enable_q <= 1'b1;
  end

  assign enable_o = enable_q;

  rsp_word_fetch #(
    .ADDR_W    (ADDR_W),
    .WORD_BYTES(WORD_BYTES)
  ) u_fetch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_go),
    .base_i      (base_i),
    .run_i       (enable_q),
    .stop_i      (term),
    .req_valid_o (req_valid_o),
    .req_ready_i (req_ready_i),
    .req_addr_o  (req_addr_o),
    .rsp_valid_i (rsp_valid_i),
    .rsp_ready_o (rsp_ready_o),
    .rsp_data_i  (rsp_data_i),
    .byte_valid_o(byte_valid),
    .byte_o      (byte_val),
    .byte_take_i (byte_take)
  );

  rsp_rec_asm #(
    .DATA_MAX(DATA_MAX)
  ) u_asm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .byte_valid_i(byte_valid),
    .byte_i      (byte_val),
    .byte_take_o (byte_take),
    .slot_free_i (slot_free),
    .slot_empty_i(slot_empty),
    .rec_done_o  (rec_done),
    .term_o      (term),
    .fields_o    (asm_fields),
    .data_o      (asm_data),
    .dlen_o      (asm_dlen)
  );

  rsp_cmd_slot #(
    .DATA_MAX(DATA_MAX)
  ) u_slot (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (rec_done),
    .fields_i    (asm_fields),
    .data_i      (asm_data),
    .dlen_i      (asm_dlen),
    .slot_free_o (slot_free),
    .slot_empty_o(slot_empty),
    .valid_o     (cmd_valid_o),
    .ready_i     (cmd_ready_i),
    .fields_o    (out_fields),
    .data_o      (cmd_data_o),
    .dlen_o      (cmd_dlen_o)
  );

  assign cmd_chan_o  = out_fields.chan;
  assign cmd_stamp_o = out_fields.stamp;
  assign cmd_rega_o  = out_fields.rega;
endmodule

// File: rtl/rec_stream_parser_chk.sv
module rec_stream_parser_chk
  import rec_stream_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 64,
  parameter int DATA_MAX   = 64
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          start_i,
  input logic                          enable_o,
  input logic                          req_valid_o,
  input logic                          req_ready_i,
  input logic [ADDR_W-1:0]             req_addr_o,
  input logic                          rsp_ready_o,
  input logic                          cmd_valid_o,
  input logic                          cmd_ready_i,
  input logic [CHAN_W-1:0]             cmd_chan_o,
  input logic [STAMP_W-1:0]            cmd_stamp_o,
  input logic [REGA_W-1:0]             cmd_rega_o,
  input logic [8*DATA_MAX-1:0]         cmd_data_o,
  input logic [$clog2(DATA_MAX+1)-1:0] cmd_dlen_o
);
  localparam int DLEN_W = $clog2(DATA_MAX + 1);

  p_req_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o));

  p_cmd_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_chan_o)
      && $stable(cmd_stamp_o) && $stable(cmd_rega_o)
      && $stable(cmd_data_o) && $stable(cmd_dlen_o));

  p_cmd_in_run_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> enable_o);

  p_fall_drained_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(enable_o) |-> !cmd_valid_o);

  p_req_in_run_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> enable_o);

  p_single_outstanding_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_o && rsp_ready_o));

  p_start_sets_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !enable_o |=> enable_o);

  p_dlen_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (cmd_dlen_o >= DLEN_W'(1)) && (cmd_dlen_o <= DLEN_W'(DATA_MAX)));

  p_zero_ext_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> ((cmd_data_o >> {cmd_dlen_o, 3'b000}) == '0));
endmodule

bind rec_stream_parser rec_stream_parser_chk #(
  .ADDR_W    (ADDR_W),
  .WORD_BYTES(WORD_BYTES),
  .DATA_MAX  (DATA_MAX)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .enable_o   (enable_o),
  .req_valid_o(req_valid_o),
  .req_ready_i(req_ready_i),
  .req_addr_o (req_addr_o),
  .rsp_ready_o(rsp_ready_o),
  .cmd_valid_o(cmd_valid_o),
  .cmd_ready_i(cmd_ready_i),
  .cmd_chan_o (cmd_chan_o),
  .cmd_stamp_o(cmd_stamp_o),
  .cmd_rega_o (cmd_rega_o),
  .cmd_data_o (cmd_data_o),
  .cmd_dlen_o (cmd_dlen_o)
);

// File: tb/rec_stream_parser_tb_top.sv
`timescale 1ns/1ps
module rec_stream_parser_tb_top;
  localparam int ADDR_W     = 32;
  localparam int WORD_BYTES = 64;
  localparam int DATA_MAX   = 64;
  localparam int WORD_W     = 8 * WORD_BYTES;
  localparam int DATA_W     = 8 * DATA_MAX;
  localparam int DLEN_W     = $clog2(DATA_MAX + 1);
  localparam int MEM_BYTES  = 4096;
  localparam int EXP_MAX    = 256;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [ADDR_W-1:0] base_i = '0;
  logic              enable_o;
  logic              req_valid_o, req_ready_i;
  logic [ADDR_W-1:0] req_addr_o;
  logic              rsp_valid_i, rsp_ready_o;
  logic [WORD_W-1:0] rsp_data_i;
  logic              cmd_valid_o, cmd_ready_i;
  logic [23:0]       cmd_chan_o;
  logic [63:0]       cmd_stamp_o;
  logic [15:0]       cmd_rega_o;
  logic [DATA_W-1:0] cmd_data_o;
  logic [DLEN_W-1:0] cmd_dlen_o;

  always #2.5 clk_i = ~clk_i;

  rec_stream_parser #(
    .ADDR_W    (ADDR_W),
    .WORD_BYTES(WORD_BYTES),
    .DATA_MAX  (DATA_MAX)
  ) dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .base_i     (base_i),
    .enable_o   (enable_o),
    .req_valid_o(req_valid_o),
    .req_ready_i(req_ready_i),
    .req_addr_o (req_addr_o),
    .rsp_valid_i(rsp_valid_i),
    .rsp_ready_o(rsp_ready_o),
    .rsp_data_i (rsp_data_i),
    .cmd_valid_o(cmd_valid_o),
    .cmd_ready_i(cmd_ready_i),
    .cmd_chan_o (cmd_chan_o),
    .cmd_stamp_o(cmd_stamp_o),
    .cmd_rega_o (cmd_rega_o),
    .cmd_data_o (cmd_data_o),
    .cmd_dlen_o (cmd_dlen_o)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [7:0]        mem [0:MEM_BYTES-1];
  logic [23:0]       e_ch [0:EXP_MAX-1];
  logic [63:0]       e_ts [0:EXP_MAX-1];
  logic [15:0]       e_ra [0:EXP_MAX-1];
  logic [DATA_W-1:0] e_dt [0:EXP_MAX-1];
  int                e_len [0:EXP_MAX-1];
  int wr_n = 0;
  int rd_n = 0;
  int wp = 0;
  int fetch_cnt = 0;
  logic [ADDR_W-1:0] exp_faddr = '0;
  int cmd_rdy_pct = 75;
  int req_rdy_pct = 70;

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic logic [WORD_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
    logic [WORD_W-1:0] w;
    for (int i = 0; i < WORD_BYTES; i++) w[8*i +: 8] = mem[(int'(a) + i) % MEM_BYTES];
    return w;
  endfunction

  // writes one record at wp; records the expected command when expect_it
  task automatic add_rec(input int dlen, input bit expect_it);
    logic [23:0]       ch = 24'($urandom);
    logic [63:0]       ts = {$urandom, $urandom};
    logic [15:0]       ra = 16'($urandom);
    logic [DATA_W-1:0] d = '0;
    int                len = dlen + 14;
    mem[wp] = 8'(len);
    for (int i = 0; i < 3; i++) mem[wp + 1 + i] = ch[8*i +: 8];
    for (int i = 0; i < 8; i++) mem[wp + 4 + i] = ts[8*i +: 8];
    for (int i = 0; i < 2; i++) mem[wp + 12 + i] = ra[8*i +: 8];
    for (int i = 0; i < dlen; i++) begin
      d[8*i +: 8] = 8'($urandom);
      mem[wp + 14 + i] = d[8*i +: 8];
    end
    if (expect_it) begin
      e_ch[wr_n] = ch; e_ts[wr_n] = ts; e_ra[wr_n] = ra;
      e_dt[wr_n] = d;  e_len[wr_n] = dlen;
      wr_n++;
    end
    wp += len;
  endtask

  task automatic fill_random(input int limit);
    while (wp + 78 <= limit) add_rec(1 + int'($urandom % DATA_MAX), 1'b1);
  endtask

  task automatic run_one(input int base, input int term_at, input bit poke, input string tag);
    int nf = (term_at - base) / WORD_BYTES + 1;
    exp_faddr = ADDR_W'(base);
    fetch_cnt = 0;
    @(negedge clk_i);
    base_i = ADDR_W'(base);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    base_i = 32'h0000_0f40;
    chk(enable_o == 1'b1, $sformatf("R7 enable after start act=%0b exp=1", enable_o));
    if (poke) begin
      repeat (20) @(negedge clk_i);
      // start while busy must not disturb the address sequence (R7)
      base_i = '0;
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    while (enable_o) @(negedge clk_i);
    chk(rd_n == wr_n, $sformatf("R8 R10 %s commands delivered act=%0d exp=%0d", tag, rd_n, wr_n));
    chk(fetch_cnt == nf, $sformatf("R6 %s word fetches act=%0d exp=%0d", tag, fetch_cnt, nf));
    chk(!cmd_valid_o, $sformatf("R8 %s output idle at end act=%0b exp=0", tag, cmd_valid_o));
    repeat (4) @(negedge clk_i);
    chk(fetch_cnt == nf && !req_valid_o && rd_n == wr_n,
        $sformatf("R6 R4 %s quiet after end fetches=%0d exp=%0d cmds=%0d exp=%0d",
                  tag, fetch_cnt, nf, rd_n, wr_n));
  endtask

  // word memory: request/response with random acceptance and latency
  initial begin
    int mst = 0;
    int dly = 0;
    logic [ADDR_W-1:0] cur = '0;
    bit hold = 1'b0;
    logic [ADDR_W-1:0] hold_addr = '0;
    req_ready_i = 1'b0;
    rsp_valid_i = 1'b0;
    rsp_data_i = '0;
    forever begin
      @(negedge clk_i);
      if (!rst_ni) continue;
      if (hold)
        chk(req_valid_o && req_addr_o == hold_addr,
            $sformatf("R11 request held act=%0b/%h exp=1/%h", req_valid_o, req_addr_o, hold_addr));
      hold = 1'b0;
      case (mst)
        0: begin
          req_ready_i = (($urandom % 100) < req_rdy_pct);
          if (req_valid_o) begin
            if (req_ready_i) begin
              chk(req_addr_o == exp_faddr,
                  $sformatf("R5 fetch address act=%h exp=%h", req_addr_o, exp_faddr));
              exp_faddr += ADDR_W'(WORD_BYTES);
              fetch_cnt++;
              cur = req_addr_o;
              dly = int'($urandom % 4);
              mst = 1;
            end else begin
              hold = 1'b1;
              hold_addr = req_addr_o;
            end
          end
        end
        1: begin
          req_ready_i = 1'b0;
          if (dly == 0) begin
            rsp_valid_i = 1'b1;
            rsp_data_i = mem_word(cur);
            mst = rsp_ready_o ? 3 : 2;
          end else begin
            dly--;
          end
        end
        2: if (rsp_ready_o) mst = 3;
        default: begin
          rsp_valid_i = 1'b0;
          rsp_data_i = {16{$urandom}};
          mst = 0;
        end
      endcase
    end
  end

  // command sink with random back-pressure
  initial begin
    bit hold = 1'b0;
    logic [23:0] h_ch = '0;
    logic [63:0] h_ts = '0;
    logic [15:0] h_ra = '0;
    logic [DATA_W-1:0] h_dt = '0;
    logic [DLEN_W-1:0] h_len = '0;
    cmd_ready_i = 1'b0;
    forever begin
      @(negedge clk_i);
      if (!rst_ni) continue;
      if (hold)
        chk(cmd_valid_o && cmd_ch_eq(h_ch, h_ts, h_ra, h_dt, h_len),
            $sformatf("R9 stalled command changed valid=%0b ch=%h exp=%h len=%0d exp=%0d",
                      cmd_valid_o, cmd_chan_o, h_ch, cmd_dlen_o, h_len));
      hold = 1'b0;
      cmd_ready_i = (($urandom % 100) < cmd_rdy_pct);
      if (cmd_valid_o) begin
        if (cmd_ready_i) begin
          if (rd_n >= wr_n) begin
            chk(1'b0, $sformatf("R4 R10 unexpected command ch=%h act_count=%0d exp_count=%0d",
                                cmd_chan_o, rd_n + 1, wr_n));
          end else begin
            chk(cmd_ch_eq(e_ch[rd_n], e_ts[rd_n], e_ra[rd_n], e_dt[rd_n], DLEN_W'(e_len[rd_n])),
                $sformatf("R1 R2 R5 R10 cmd %0d act ch=%h ts=%h ra=%h len=%0d d=%h exp ch=%h ts=%h ra=%h len=%0d d=%h",
                          rd_n, cmd_chan_o, cmd_stamp_o, cmd_rega_o, cmd_dlen_o, cmd_data_o,
                          e_ch[rd_n], e_ts[rd_n], e_ra[rd_n], e_len[rd_n], e_dt[rd_n]));
            rd_n++;
          end
        end else begin
          hold = 1'b1;
          h_ch = cmd_chan_o; h_ts = cmd_stamp_o; h_ra = cmd_rega_o;
          h_dt = cmd_data_o; h_len = cmd_dlen_o;
        end
      end
    end
  end

  function automatic bit cmd_ch_eq(input logic [23:0] ch, input logic [63:0] ts,
                                   input logic [15:0] ra, input logic [DATA_W-1:0] dt,
                                   input logic [DLEN_W-1:0] len);
    return cmd_chan_o == ch && cmd_stamp_o == ts && cmd_rega_o == ra
        && cmd_data_o == dt && cmd_dlen_o == len;
  endfunction

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int t;
    void'($urandom(32'd7321));
    for (int i = 0; i < MEM_BYTES; i++) mem[i] = 8'($urandom);
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!enable_o && !cmd_valid_o && !req_valid_o,
        $sformatf("R7 R8 reset state en=%0b cv=%0b rv=%0b exp=0/0/0", enable_o, cmd_valid_o, req_valid_o));

    // run at 0: largest and smallest data, then random lengths
    wp = 0;
    add_rec(DATA_MAX, 1'b1);
    add_rec(1, 1'b1);
    fill_random(500);
    t = wp; mem[wp] = 8'd0; wp++;
    run_one(0, t, 1'b0, "base0");

    // independent run at 512 under heavy stall
    cmd_rdy_pct = 30;
    wp = 512;
    fill_random(1010);
    t = wp; mem[wp] = 8'd0; wp++;
    run_one(512, t, 1'b0, "base512");

    // length 14 (one below minimum) ends the run; later record ignored
    cmd_rdy_pct = 90;
    wp = 1024;
    add_rec(3, 1'b1);
    add_rec(40, 1'b1);
    t = wp; mem[wp] = 8'd14; wp++;
    add_rec(5, 1'b0);
    mem[wp] = 8'd0;
    run_one(1024, t, 1'b0, "R4 len14");

    // length above maximum ends the run
    wp = 1536;
    add_rec(5, 1'b1);
    t = wp; mem[wp] = 8'(14 + DATA_MAX + 1); wp++;
    add_rec(2, 1'b0);
    mem[wp] = 8'd0;
    run_one(1536, t, 1'b0, "R4 len79");

    // immediate terminator: no commands, one word
    wp = 2048;
    mem[wp] = 8'd0;
    run_one(2048, 2048, 1'b0, "R3 empty");

    // record ending on a word boundary, a straddling record, busy start
    cmd_rdy_pct = 100;
    wp = 2560;
    add_rec(WORD_BYTES - 14, 1'b1);
    add_rec(DATA_MAX, 1'b1);
    add_rec(1, 1'b1);
    fill_random(2900);
    t = wp; mem[wp] = 8'd0; wp++;
    run_one(2560, t, 1'b1, "R7 busy start");

    // short records back to back, output mostly stalled
    cmd_rdy_pct = 8;
    wp = 3072;
    for (int i = 0; i < 12; i++) add_rec(1 + int'($urandom % 4), 1'b1);
    fill_random(3600);
    t = wp; mem[wp] = 8'd0; wp++;
    run_one(3072, t, 1'b0, "R9 stall");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule